// File: doc/BRIEF.md
# Configurable Pin Interrupt Detector

This block turns a vector of already-synchronized general-purpose pin values into interrupt status. Each pin is set up on its own. It can watch for a level, for any change of value, or for one chosen edge. When a pin's condition is met, its raw status bit is set and stays set until software clears it. An enable mask selects which raw bits appear in the masked status vector and which ones drive the single combined interrupt line.

The surrounding register file holds the configuration vectors and feeds them in as plain inputs:
- `dir_out`: a 1 marks a pin as an output.
- `sense_lvl`: a 1 selects level detection.
- `edge_both`: a 1 selects detection of both edges.
- `pol`: the active level, or the active edge.
- `int_mask`: the interrupt enable mask.

A clear operation is a one-cycle `clr_strobe` together with a bit vector `clr_data`. Each bit of `clr_data` that is 1 clears the matching raw bit.

Inside the block there are two small state machines.
- **Arming machine.** It has two states, ARM_WAIT and ARM_LIVE. Reset puts it in ARM_WAIT. It moves to ARM_LIVE on the first clock after reset and stays there. While it is in ARM_WAIT, the copy of the previous pin values is loaded, but no edge is reported.
- **Per-pin mode decode.** Each pin's mode is one of DET_LEVEL (`sense_lvl`=1), DET_EDGE_BOTH (`sense_lvl`=0, `edge_both`=1) or DET_EDGE_ONE (`sense_lvl`=0, `edge_both`=0). A pin moves between modes whenever its configuration bits change.

Top module: `pin_irq_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `raw_o`, `masked_o` and `irq_o` are all 0.
- R2: Edge events set status only on pins whose `dir_out` bit is 0. Level detection is not gated by `dir_out`.
- R3: A pin with `sense_lvl`=1 sets its raw bit at every clock edge where its input equals its `pol` bit.
- R4: A pin with `sense_lvl`=0 and `edge_both`=1 sets its raw bit on any change of its input, rising or falling.
- R5: A pin with `sense_lvl`=0 and `edge_both`=0 sets its raw bit only on a change whose new value equals its `pol` bit. `pol`=1 means a rising edge and `pol`=0 means a falling edge.
- R6: Raw bits are sticky. At an edge where `clr_strobe`=1, each `clr_data` bit that is 1 clears the matching raw bit, and each bit that is 0 leaves it unchanged.
- R7: If a new event and a clear hit the same bit at the same edge, the event wins and the bit stays 1. A level-mode bit therefore cannot be cleared while its level is still active.
- R8: `masked_o` equals `raw_o` AND `int_mask` in the same cycle. `irq_o` is registered and shows the OR of `masked_o` one clock later.
- R9: The first clock edge after reset records the pin values without reporting an edge, so pins that are already high do not raise status.
- R10: A raw bit changes at the clock edge that samples the input value causing it, so it is visible one clock after the input is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | PIN_COUNT | Synchronized pin values |
| dir_out | input | PIN_COUNT | 1 = pin is an output |
| sense_lvl | input | PIN_COUNT | 1 = level detection, 0 = edge detection |
| edge_both | input | PIN_COUNT | 1 = both edges (edge mode only) |
| pol | input | PIN_COUNT | Active level / active edge |
| int_mask | input | PIN_COUNT | Interrupt enable mask |
| clr_strobe | input | 1 | Clear request, one cycle |
| clr_data | input | PIN_COUNT | Bits to clear when `clr_strobe` is 1 |
| raw_o | output | PIN_COUNT | Sticky raw status |
| masked_o | output | PIN_COUNT | Raw status gated by the mask |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
A change on `pin_in`, `clr_strobe` or the configuration takes effect at the next rising edge. It appears on `raw_o` and `masked_o` right after that edge. `irq_o` follows one more edge later. The bench drives every input at the falling edge. It samples `raw_o` and `masked_o` at the falling edge right after the first rising edge, and samples `irq_o` a full cycle after that. The latency test also confirms that `irq_o` is still low at the earlier sample point.

// File: rtl/pid_pkg.sv
package pid_pkg;

    typedef enum logic [1:0] {
        DET_LEVEL     = 2'd0,
        DET_EDGE_BOTH = 2'd1,
        DET_EDGE_ONE  = 2'd2
    } det_mode_e;

    typedef enum logic {
        ARM_WAIT = 1'b0,
        ARM_LIVE = 1'b1
    } arm_state_e;

    function automatic det_mode_e pick_mode(input logic lvl, input logic both);
        if (lvl)
            return DET_LEVEL;
        else if (both)
            return DET_EDGE_BOTH;
        else
            return DET_EDGE_ONE;
    endfunction

endpackage

// File: rtl/pid_arm_fsm.sv
module pid_arm_fsm
    import pid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic armed
);

    arm_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ARM_WAIT;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARM_WAIT: state_d = ARM_LIVE;
            ARM_LIVE: state_d = ARM_LIVE;
            default:  state_d = ARM_WAIT;
        endcase
    end

    always_comb begin
        armed = (state_q == ARM_LIVE);
    end

endmodule

// File: rtl/pid_pin_cell.sv
module pid_pin_cell
    import pid_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic pin,
    input  logic is_output,
    input  logic lvl_sel,
    input  logic both_sel,
    input  logic pol_bit,
    input  logic clr_hit,
    output logic raw
);

    logic      prev_q;
    logic      raw_q;
    logic      hit;
    logic      moved;
    det_mode_e mode;

    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= pin;
    end

    always_comb begin
        mode  = pick_mode(lvl_sel, both_sel);
        moved = armed & ~is_output & (pin ^ prev_q);
        hit   = 1'b0;
        unique case (mode)
            DET_LEVEL:     hit = (pin == pol_bit);
            DET_EDGE_BOTH: hit = moved;
            DET_EDGE_ONE:  hit = moved & (pin == pol_bit);
            default:       hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else
            raw_q <= (raw_q & ~clr_hit) | hit;
    end

    assign raw = raw_q;

endmodule

// File: rtl/pid_irq_merge.sv
module pid_irq_merge #(
    parameter int PIN_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] raw,
    input  logic [PIN_COUNT-1:0] enable,
    output logic [PIN_COUNT-1:0] masked,
    output logic                 irq
);

    logic irq_q;

    always_comb begin
        masked = raw & enable;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |masked;
    end

    assign irq = irq_q;

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
    parameter int PIN_COUNT = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pin_in,
    input  logic [PIN_COUNT-1:0] dir_out,
    input  logic [PIN_COUNT-1:0] sense_lvl,
    input  logic [PIN_COUNT-1:0] edge_both,
    input  logic [PIN_COUNT-1:0] pol,
    input  logic [PIN_COUNT-1:0] int_mask,
    input  logic                 clr_strobe,
    input  logic [PIN_COUNT-1:0] clr_data,
    output logic [PIN_COUNT-1:0] raw_o,
    output logic [PIN_COUNT-1:0] masked_o,
    output logic                 irq_o
);

    logic                 armed;
    logic [PIN_COUNT-1:0] clr_vec;
    logic [PIN_COUNT-1:0] raw_vec;

    assign clr_vec = clr_strobe ? clr_data : '0;

    pid_arm_fsm u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed)
    );

    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_pin
        pid_pin_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .armed     (armed),
            .pin       (pin_in[g]),
            .is_output (dir_out[g]),
            .lvl_sel   (sense_lvl[g]),
            .both_sel  (edge_both[g]),
            .pol_bit   (pol[g]),
            .clr_hit   (clr_vec[g]),
            .raw       (raw_vec[g])
        );
    end

    pid_irq_merge #(.PIN_COUNT(PIN_COUNT)) u_merge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw_vec),
        .enable (int_mask),
        .masked (masked_o),
        .irq    (irq_o)
    );

    assign raw_o = raw_vec;

endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
    parameter int PIN_COUNT = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PIN_COUNT-1:0] pin_in,
    input logic [PIN_COUNT-1:0] dir_out,
    input logic [PIN_COUNT-1:0] sense_lvl,
    input logic [PIN_COUNT-1:0] pol,
    input logic                 clr_strobe,
    input logic [PIN_COUNT-1:0] clr_data,
    input logic [PIN_COUNT-1:0] raw_o,
    input logic [PIN_COUNT-1:0] masked_o,
    input logic                 irq_o
);

    logic [PIN_COUNT-1:0] keep_vec;
    logic [PIN_COUNT-1:0] lvl_vec;
    logic [PIN_COUNT-1:0] out_edge_vec;

    assign keep_vec     = raw_o & ~(clr_strobe ? clr_data : '0);
    assign lvl_vec      = sense_lvl & ~(pin_in ^ pol);
    assign out_edge_vec = dir_out & ~sense_lvl;

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((raw_o & $past(keep_vec)) == $past(keep_vec))); // R6

    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((raw_o & $past(lvl_vec)) == $past(lvl_vec))); // R3

    AST_OUTPUT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((raw_o & ~$past(raw_o) & $past(out_edge_vec)) == '0)); // R2

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == $past(|masked_o))); // R8

    AST_FRESH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (raw_o == '0 && !irq_o)); // R1

endmodule

bind pin_irq_detect pin_irq_detect_chk #(.PIN_COUNT(PIN_COUNT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .dir_out    (dir_out),
    .sense_lvl  (sense_lvl),
    .pol        (pol),
    .clr_strobe (clr_strobe),
    .clr_data   (clr_data),
    .raw_o      (raw_o),
    .masked_o   (masked_o),
    .irq_o      (irq_o)
);

// File: tb/tb_pin_irq_detect.sv
`timescale 1ns/1ps
module tb_pin_irq_detect;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] pin_in, dir_out, sense_lvl, edge_both, pol, int_mask, clr_data;
    logic       clr_strobe;
    logic [7:0] raw_o, masked_o;
    logic       irq_o;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    pin_irq_detect #(.PIN_COUNT(8)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .dir_out(dir_out),
        .sense_lvl(sense_lvl), .edge_both(edge_both), .pol(pol),
        .int_mask(int_mask), .clr_strobe(clr_strobe), .clr_data(clr_data),
        .raw_o(raw_o), .masked_o(masked_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [7:0] sense, both, pl, dir, msk, a, b, exp;
    } vec_t;

    localparam vec_t VEC [0:4] = '{
        '{8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'hA5, 8'hA5}, // R4 both edges
        '{8'h00, 8'h00, 8'h0F, 8'h00, 8'hF0, 8'h33, 8'h55, 8'h24}, // R5 single edge
        '{8'hFF, 8'h00, 8'hF0, 8'hFF, 8'h0C, 8'h0F, 8'hF3, 8'hFC}, // R3 level, R2 no dir gate
        '{8'h00, 8'hFF, 8'h00, 8'hF0, 8'hF0, 8'h00, 8'hFF, 8'h0F}, // R2 outputs ignored
        '{8'h0F, 8'h30, 8'h05, 8'h80, 8'h01, 8'h00, 8'hF0, 8'h3A}  // mixed modes
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #500000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pin_in = 8'hFF; dir_out = 8'h00; sense_lvl = 8'h00;
        edge_both = 8'hFF; pol = 8'h00; int_mask = 8'hFF;
        clr_strobe = 1'b0; clr_data = 8'h00;
        step(); step();
        check("R1 raw", raw_o, 8'h00);
        check("R1 masked", masked_o, 8'h00);
        check("R1 irq", {7'd0, irq_o}, 8'h00);
        rst_n = 1'b1;
        step(); step(); step();
        check("R9 no edge at arm", raw_o, 8'h00);

        for (int i = 0; i < 5; i++) begin
            sense_lvl = VEC[i].sense; edge_both = VEC[i].both; pol = VEC[i].pl;
            dir_out = VEC[i].dir; int_mask = VEC[i].msk; pin_in = VEC[i].a;
            step(); step();
            clr_strobe = 1'b1; clr_data = 8'hFF;
            step();
            clr_strobe = 1'b0; clr_data = 8'h00; pin_in = VEC[i].b;
            step();
            check("R10 vector raw", raw_o, VEC[i].exp);
            check("R8 vector masked", masked_o, VEC[i].exp & VEC[i].msk);
            step();
            check("R8 vector irq", {7'd0, irq_o}, {7'd0, |(VEC[i].exp & VEC[i].msk)});
        end

        sense_lvl = 8'h00; edge_both = 8'hFF; pol = 8'h00; dir_out = 8'h00;
        int_mask = 8'h01; pin_in = 8'hFF;
        step(); step();
        clr_strobe = 1'b1; clr_data = 8'hFF;
        step();
        clr_strobe = 1'b0; clr_data = 8'h00;
        step();
        check("R6 cleared", raw_o, 8'h00);
        pin_in = 8'hFE;
        step();
        check("R10 raw next edge", raw_o, 8'h01);
        check("R8 irq not yet", {7'd0, irq_o}, 8'h00);
        step();
        check("R8 irq after one", {7'd0, irq_o}, 8'h01);

        pin_in = 8'hFC;
        step(); step(); step();
        check("R6 sticky", raw_o, 8'h03);
        clr_strobe = 1'b1; clr_data = 8'h02;
        step();
        clr_strobe = 1'b0; clr_data = 8'h00;
        check("R6 partial clear", raw_o, 8'h01);

        clr_strobe = 1'b1; clr_data = 8'h01; pin_in = 8'hFD;
        step();
        clr_strobe = 1'b0; clr_data = 8'h00;
        check("R7 event beats clear", raw_o, 8'h01);

        sense_lvl = 8'h04; pol = 8'h04;
        step();
        check("R3 level set", raw_o, 8'h05);
        clr_strobe = 1'b1; clr_data = 8'h04;
        step();
        check("R7 level holds", raw_o, 8'h05);
        pin_in = 8'hF9;
        step();
        clr_strobe = 1'b0; clr_data = 8'h00;
        check("R7 level clears when idle", raw_o, 8'h01);

        finish_run();
    end

endmodule